// File: doc/BRIEF.md
# Extended-Register Operand Adder/Subtractor

This block is the integer add/subtract datapath of a processor execute stage. Its second operand comes from a register and is prepared before the arithmetic. The block picks a low field of that value: a byte, a halfword, a word or the full doubleword. It widens the field by zero or sign extension and shifts it left by 0 to 4 bits. The prepared value is then added to or subtracted from the first operand.

The operation works at one of two sizes. In the narrow (32-bit) size the field widens to 32 bits, the arithmetic and the flags use the low 32 bits, and the upper half of the result port reads zero. In the wide (64-bit) size everything is 64 bits.

The result, the four condition flags and an illegal-shift indication are registered. They appear one cycle after a valid request and are held between requests.

Top module: `xreg_addsub`

## Requirements
- R1: `ext_sel[1:0]` picks the field taken from `opb`: 00 = low 8 bits, 01 = low 16 bits, 10 = low 32 bits, 11 = all 64 bits. `ext_sel[2]` = 1 fills the upper bits with the field's top bit (sign extension). `ext_sel[2]` = 0 fills them with zeros.
- R2: With `wide` = 0, the selected field widens to 32 bits and the arithmetic is done on the low 32 bits of `opa`. `result[63:32]` is zero. A doubleword selection then behaves as a word selection.
- R3: The extended operand is shifted left by `shamt` (0 to 4) before the arithmetic. Bits shifted past the operation size are lost.
- R4: `bad_shift` is 1 for `shamt` values 5, 6 and 7 and 0 for values 0 to 4. When it is 1, the result and the flags carry no meaning.
- R5: With `is_sub` = 0, `result` is `opa` plus the prepared operand, modulo 2^size.
- R6: With `is_sub` = 1, `result` is `opa` minus the prepared operand, modulo 2^size.
- R7: `flag_n` is the top bit of the size-wide result: bit 63 in wide size, bit 31 in narrow size. `flag_z` is 1 exactly when the size-wide result is zero.
- R8: `flag_c` is the unsigned carry out of an add. For a subtract, it is 1 when no borrow occurs, that is when `opa` ≥ the prepared operand as unsigned values.
- R9: `flag_v` is 1 when the true two's-complement sum or difference does not fit in the operation size.
- R10: A request with `in_valid` = 1 at a rising edge drives `out_valid` = 1 together with its result and flags after that same edge. If `in_valid` = 0 at an edge, `out_valid` becomes 0 and `result`, the flags and `bad_shift` keep their previous values.
- R11: While `rst` is high at a rising edge, `out_valid`, `result`, all flags and `bad_shift` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| is_sub | input | 1 | 1 = subtract, 0 = add |
| wide | input | 1 | 1 = 64-bit size, 0 = 32-bit size |
| ext_sel | input | 3 | Signed flag (bit 2) and field size (bits 1:0) |
| shamt | input | 3 | Left shift applied after extension |
| opa | input | 64 | First operand |
| opb | input | 64 | Register value that supplies the second operand |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Sum or difference |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_c | output | 1 | Carry / no borrow |
| flag_v | output | 1 | Signed overflow |
| bad_shift | output | 1 | Shift amount out of range |

## Verification
A single request can do several things at once. Sign extension of a narrow field can produce a large negative operand, and the shift can then drive bits past the size boundary, in the same operation that raises both the carry and the overflow flag.

The sweep provokes these coincidences by crossing every extend selection, every legal shift, both sizes and both operations. The operand set is built around the boundary values: all ones, the top-bit-only patterns of each half, and the largest positive values. Each outcome is judged against an arithmetic model in the bench that does the sum at 128 bits with a sign. That model derives carry from a wide unsigned sum or a plain compare, and overflow from whether the wide result still fits the size.

// File: rtl/xreg_addsub_pkg.sv
package xreg_addsub_pkg;

   // Field size selected by ext_sel[1:0]
   typedef enum logic [1:0] {
      FLD_BYTE  = 2'b00,
      FLD_HALF  = 2'b01,
      FLD_WORD  = 2'b10,
      FLD_DWORD = 2'b11
   } fld_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } nzcv_t;

endpackage

// File: rtl/xreg_extend.sv
module xreg_extend #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] src,
   input  logic [2:0]      sel,
   input  logic            wide,
   output logic [XLEN-1:0] ext
);
   localparam int HALF = XLEN / 2;
   localparam int NFLD = 4;

   logic [NFLD-1:0][XLEN-1:0] cand;
   logic [XLEN-1:0]           full;
   logic                      signed_sel;

   assign signed_sel = sel[2];

   // One candidate per field size; the full width needs no fill
   for (genvar k = 0; k < NFLD; k++) begin : g_fld
      localparam int FW = XLEN >> (NFLD - 1 - k);
      if (FW == XLEN) begin : g_full
         assign cand[k] = src;
      end else begin : g_part
         logic fill;
         assign fill    = signed_sel & src[FW-1];
         assign cand[k] = {{(XLEN-FW){fill}}, src[FW-1:0]};
      end
   end

   always_comb begin
      full = cand[sel[1:0]];
      if (wide) ext = full;
      else      ext = {{HALF{1'b0}}, full[HALF-1:0]};
   end
endmodule

// File: rtl/xreg_shift.sv
module xreg_shift #(
   parameter int XLEN = 64,
   parameter int SHW  = 3
) (
   input  logic [XLEN-1:0] din,
   input  logic [SHW-1:0]  amt,
   input  logic            wide,
   output logic [XLEN-1:0] dout
);
   localparam int HALF = XLEN / 2;

   logic [SHW:0][XLEN-1:0] stg;

   assign stg[0] = din;

   // Logarithmic shifter: stage i moves by 2**i
   for (genvar i = 0; i < SHW; i++) begin : g_stage
      assign stg[i+1] = amt[i] ? (stg[i] << (2**i)) : stg[i];
   end

   always_comb begin
      if (wide) dout = stg[SHW];
      else      dout = {{HALF{1'b0}}, stg[SHW][HALF-1:0]};
   end
endmodule

// File: rtl/xreg_core.sv
module xreg_core
   import xreg_addsub_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] res,
   output nzcv_t        flags
);
   logic [W-1:0] bop;
   logic [W:0]   sum;

   always_comb begin
      bop       = sub ? ~b : b;
      sum       = {1'b0, a} + {1'b0, bop} + {{W{1'b0}}, sub};
      res       = sum[W-1:0];
      flags.n   = sum[W-1];
      flags.z   = (sum[W-1:0] == '0);
      flags.c   = sum[W];
      flags.v   = (a[W-1] == bop[W-1]) && (sum[W-1] != a[W-1]);
   end
endmodule

// File: rtl/xreg_addsub.sv
module xreg_addsub
   import xreg_addsub_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int SHW       = 3,
   parameter int MAX_SHIFT = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   input  logic            is_sub,
   input  logic            wide,
   input  logic [2:0]      ext_sel,
   input  logic [SHW-1:0]  shamt,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   output logic            out_valid,
   output logic [XLEN-1:0] result,
   output logic            flag_n,
   output logic            flag_z,
   output logic            flag_c,
   output logic            flag_v,
   output logic            bad_shift
);
   localparam int HALF = XLEN / 2;

   // Elaboration-time parameter checks
   if (XLEN % 8 != 0 || XLEN < 16) begin : g_bad_xlen
      $error("xreg_addsub: XLEN must be a multiple of 8 and at least 16");
   end
   if (SHW < 1 || MAX_SHIFT >= (2**SHW)) begin : g_bad_shw
      $error("xreg_addsub: MAX_SHIFT must be encodable in SHW bits");
   end

   logic [XLEN-1:0] ext_val;
   logic [XLEN-1:0] sh_val;
   logic [XLEN-1:0] res_w;
   logic [HALF-1:0] res_n;
   nzcv_t           fl_w;
   nzcv_t           fl_n;
   logic [XLEN-1:0] res_sel;
   nzcv_t           fl_sel;
   logic            sh_bad;

   xreg_extend #(.XLEN(XLEN)) u_ext (
      .src (opb),
      .sel (ext_sel),
      .wide(wide),
      .ext (ext_val)
   );

   xreg_shift #(.XLEN(XLEN), .SHW(SHW)) u_shift (
      .din (ext_val),
      .amt (shamt),
      .wide(wide),
      .dout(sh_val)
   );

   xreg_core #(.W(XLEN)) u_core_w (
      .a    (opa),
      .b    (sh_val),
      .sub  (is_sub),
      .res  (res_w),
      .flags(fl_w)
   );

   xreg_core #(.W(HALF)) u_core_n (
      .a    (opa[HALF-1:0]),
      .b    (sh_val[HALF-1:0]),
      .sub  (is_sub),
      .res  (res_n),
      .flags(fl_n)
   );

   always_comb begin
      sh_bad = (int'(shamt) > MAX_SHIFT);
      if (wide) begin
         res_sel = res_w;
         fl_sel  = fl_w;
      end else begin
         res_sel = {{HALF{1'b0}}, res_n};
         fl_sel  = fl_n;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         result    <= '0;
         flag_n    <= 1'b0;
         flag_z    <= 1'b0;
         flag_c    <= 1'b0;
         flag_v    <= 1'b0;
         bad_shift <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result    <= res_sel;
            flag_n    <= fl_sel.n;
            flag_z    <= fl_sel.z;
            flag_c    <= fl_sel.c;
            flag_v    <= fl_sel.v;
            bad_shift <= sh_bad;
         end
      end
   end
endmodule

// File: rtl/xreg_addsub_chk.sv
module xreg_addsub_chk #(
   parameter int XLEN      = 64,
   parameter int SHW       = 3,
   parameter int MAX_SHIFT = 4
) (
   input logic            clk,
   input logic            rst,
   input logic            in_valid,
   input logic            is_sub,
   input logic            wide,
   input logic [2:0]      ext_sel,
   input logic [SHW-1:0]  shamt,
   input logic [XLEN-1:0] opa,
   input logic [XLEN-1:0] opb,
   input logic            out_valid,
   input logic [XLEN-1:0] result,
   input logic            flag_n,
   input logic            flag_z,
   input logic            flag_c,
   input logic            flag_v,
   input logic            bad_shift
);
   localparam int HALF = XLEN / 2;

   // Set once a full cycle out of reset has passed
   logic armed;
   always_ff @(posedge clk) begin
      if (rst) armed <= 1'b0;
      else     armed <= 1'b1;
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      armed |-> (out_valid == $past(in_valid))); // R10

   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
      (armed && !in_valid) |=> ($stable(result) && $stable(bad_shift))); // R10

   AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(in_valid) && !$past(wide)) |-> (result[XLEN-1:HALF] == '0)); // R2

   AST_SHIFT_RANGE: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(in_valid)) |-> (bad_shift == (int'($past(shamt)) > MAX_SHIFT))); // R4

   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(in_valid)) |-> (flag_z == (result == '0))); // R7

   AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(in_valid)) |->
         (flag_n == ($past(wide) ? result[XLEN-1] : result[HALF-1]))); // R7

   AST_PLAIN_ADD: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(in_valid) && $past(wide) && !$past(is_sub)
       && $past(ext_sel) == 3'b011 && $past(shamt) == '0)
      |-> (result == $past(opa) + $past(opb))); // R5
endmodule

bind xreg_addsub xreg_addsub_chk #(
   .XLEN(XLEN), .SHW(SHW), .MAX_SHIFT(MAX_SHIFT)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .is_sub   (is_sub),
   .wide     (wide),
   .ext_sel  (ext_sel),
   .shamt    (shamt),
   .opa      (opa),
   .opb      (opb),
   .out_valid(out_valid),
   .result   (result),
   .flag_n   (flag_n),
   .flag_z   (flag_z),
   .flag_c   (flag_c),
   .flag_v   (flag_v),
   .bad_shift(bad_shift)
);

// File: tb/test_xreg_addsub.sv
`timescale 1ns/1ps
module test_xreg_addsub;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic        is_sub;
   logic        wide;
   logic [2:0]  ext_sel;
   logic [2:0]  shamt;
   logic [63:0] opa;
   logic [63:0] opb;
   logic        out_valid;
   logic [63:0] result;
   logic        flag_n, flag_z, flag_c, flag_v;
   logic        bad_shift;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   xreg_addsub i_xreg_addsub (
      .clk(clk), .rst(rst), .in_valid(in_valid), .is_sub(is_sub),
      .wide(wide), .ext_sel(ext_sel), .shamt(shamt), .opa(opa), .opb(opb),
      .out_valid(out_valid), .result(result), .flag_n(flag_n),
      .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v), .bad_shift(bad_shift)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   function automatic logic [63:0] pat(input int i);
      case (i)
         0:  return 64'h0;
         1:  return 64'h1;
         2:  return 64'h10;
         3:  return 64'hFFFF_FFFF_FFFF_FFFF;
         4:  return 64'h8000_0000_0000_0000;
         5:  return 64'h7FFF_FFFF_FFFF_FFFF;
         6:  return 64'h0000_0000_8000_0000;
         7:  return 64'h0000_0000_7FFF_FFFF;
         8:  return 64'h1234_5678_9ABC_DEF0;
         9:  return 64'hFFFF_FFFF_FFFF_FF80;
         10: return 64'h0000_0000_0000_8000;
         default: return 64'h0000_0000_FFFF_FFFE;
      endcase
   endfunction

   // Arithmetic reference model
   task automatic model(input logic w, input logic s, input logic [2:0] sel,
                        input int sh, input logic [63:0] a, input logic [63:0] b,
                        output logic [63:0] r, output logic [3:0] f);
      int fw;
      logic [63:0] m, e, wm, shv, aw;
      logic signed [127:0] sa, sb, sr;
      logic [64:0] u;
      logic n, z, c, v;
      fw = 8 << sel[1:0];
      if (!w && fw > 32) fw = 32;
      m  = (fw == 64) ? '1 : ((64'd1 << fw) - 64'd1);
      e  = b & m;
      if (sel[2] && b[fw-1]) e = e | ~m;
      wm  = w ? '1 : 64'hFFFF_FFFF;
      e   = e & wm;
      shv = (e << sh) & wm;
      aw  = a & wm;
      sa = w ? {{64{aw[63]}}, aw} : {{96{aw[31]}}, aw[31:0]};
      sb = w ? {{64{shv[63]}}, shv} : {{96{shv[31]}}, shv[31:0]};
      sr = s ? sa - sb : sa + sb;
      r  = sr[63:0] & wm;
      v  = w ? (sr != {{64{sr[63]}}, sr[63:0]}) : (sr != {{96{sr[31]}}, sr[31:0]});
      n  = w ? r[63] : r[31];
      z  = (r == 64'd0);
      if (s) c = (aw >= shv);
      else begin
         u = {1'b0, aw} + {1'b0, shv};
         c = w ? u[64] : u[32];
      end
      f = {n, z, c, v};
   endtask

   task automatic drive(input logic w, input logic s, input logic [2:0] sel,
                        input logic [2:0] sh, input logic [63:0] a, input logic [63:0] b);
      @(negedge clk);
      in_valid = 1'b1; wide = w; is_sub = s; ext_sel = sel; shamt = sh; opa = a; opb = b;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] er;
      logic [3:0]  ef;
      logic [63:0] acc;
      logic [63:0] held;
      rst = 1'b1; in_valid = 1'b0; is_sub = 1'b0; wide = 1'b1;
      ext_sel = 3'b0; shamt = 3'd0; opa = '0; opb = '0;
      repeat (3) @(posedge clk);
      #1;
      // R11: reset state
      chk("R11 out_valid", {63'd0, out_valid}, 64'd0);
      chk("R11 result", result, 64'd0);
      chk("R11 flags+bad", {59'd0, flag_n, flag_z, flag_c, flag_v, bad_shift}, 64'd0);
      @(negedge clk); rst = 1'b0;

      // R3/R5: running sum, zero-extended word 2 at shifts 0..4
      acc = 64'h10;
      for (int k = 0; k <= 4; k++) begin
         drive(1'b1, 1'b0, 3'b010, 3'(k), acc, 64'd2);
         acc = acc + (64'd2 << k);
         chk("R3 running sum", result, acc);
      end
      chk("R3 final sum", result, 64'h4E);

      // R1: zero-extended word 0xFFFFFFFE shifted by 4
      drive(1'b1, 1'b0, 3'b010, 3'd4, 64'd0, 64'hFFFF_FFFF_FFFF_FFFE);
      chk("R1 zero-extend word", result, 64'hF_FFFF_FFE0);
      // R1: sign-extended word -2 added to 0x10
      drive(1'b1, 1'b0, 3'b110, 3'd0, 64'h10, 64'h0000_0000_FFFF_FFFE);
      chk("R1 sign-extend word", result, 64'hE);
      // R1/R2: halfword 0x8000 in narrow size
      drive(1'b0, 1'b0, 3'b101, 3'd0, 64'd0, 64'h8000);
      chk("R2 sign half narrow", result, 64'hFFFF_8000);
      drive(1'b0, 1'b0, 3'b001, 3'd0, 64'd0, 64'h8000);
      chk("R2 zero half narrow", result, 64'h8000);
      drive(1'b1, 1'b0, 3'b101, 3'd0, 64'd0, 64'h8000);
      chk("R1 sign half wide", result, 64'hFFFF_FFFF_FFFF_8000);

      // R4: illegal shift amounts
      for (int k = 5; k <= 7; k++) begin
         drive(1'b1, 1'b0, 3'b011, 3'(k), 64'd1, 64'd1);
         chk("R4 bad_shift set", {63'd0, bad_shift}, 64'd1);
      end
      drive(1'b1, 1'b0, 3'b011, 3'd4, 64'd1, 64'd1);
      chk("R4 bad_shift clear", {63'd0, bad_shift}, 64'd0);

      // R10: hold when no request
      held = result;
      @(negedge clk);
      in_valid = 1'b0; opa = 64'hDEAD; opb = 64'hBEEF; shamt = 3'd7;
      @(posedge clk); #1;
      chk("R10 out_valid low", {63'd0, out_valid}, 64'd0);
      chk("R10 result held", result, held);
      chk("R10 bad_shift held", {63'd0, bad_shift}, 64'd0);

      // Sweep: sizes, ops, selections, legal shifts, operand patterns
      for (int w = 0; w < 2; w++)
         for (int s = 0; s < 2; s++)
            for (int sel = 0; sel < 8; sel++)
               for (int sh = 0; sh <= 4; sh++)
                  for (int ia = 0; ia < 12; ia++)
                     for (int ib = 0; ib < 12; ib++) begin
                        model(w[0], s[0], 3'(sel), sh, pat(ia), pat(ib), er, ef);
                        drive(w[0], s[0], 3'(sel), 3'(sh), pat(ia), pat(ib));
                        chk("R10 out_valid", {63'd0, out_valid}, 64'd1);
                        chk(s ? "R6/R1/R3/R2 difference" : "R5/R1/R3/R2 sum", result, er);
                        chk("R7 N", {63'd0, flag_n}, {63'd0, ef[3]});
                        chk("R7 Z", {63'd0, flag_z}, {63'd0, ef[2]});
                        chk("R8 C", {63'd0, flag_c}, {63'd0, ef[1]});
                        chk("R9 V", {63'd0, flag_v}, {63'd0, ef[0]});
                     end

      // R11: reset mid-run clears outputs
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1;
      chk("R11 reset result", result, 64'd0);
      chk("R11 reset valid", {63'd0, out_valid}, 64'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule